// File: doc/BRIEF.md
# Indirect-Access Interrupt Routing Register Block

This block holds the programmable routing state for a set of interrupt pins. Software does not address the table directly. It first writes an index into a select register, then reads or writes a 32-bit data window that shows whichever word that index names. The index space holds a 4-bit device identifier, a read-only version word and, from index 0x10 upward, one 64-bit routing entry per pin. Each entry is reached as an even (low) half and an odd (high) half.

The full table is presented on an output bus every cycle for the pin logic. The pin logic reports when a level-triggered pin has been serviced by pulsing a per-pin in-service set input. The block answers with two registered one-cycle pulse vectors. One flags a write that flipped an entry's mask bit. The other flags any accepted write to an entry. The bus port sees only the low byte of the address, a byte count and 32 bits of data.

Top module: `irq_route_regs`

## Requirements
- R1: After reset the select register and the identifier read 0. Every entry equals 64'h0000_0000_0001_0000, with only the mask bit 16 set. Both pulse vectors are 0.
- R2: Offset 0x00 is the select register, 8 bits wide, zero-extended on read. Offset 0x10 is the data window. Every other offset reads 0 and ignores writes. `bus_rdata` is loaded at the clock edge that samples `bus_rd` and holds its value otherwise.
- R3: A window write with select 0x00 loads the identifier from data bits 27:24. Selects 0x00 and 0x02 both read the identifier in bits 27:24 with all other bits 0. Writes through select 0x02 are ignored.
- R4: Select 0x01 reads {8'h00, NPINS-1, 8'h00, VERSION}, which is 32'h0017_0011 with the default parameters. Writes through it are ignored.
- R5: A select s of 0x10 or above addresses entry (s-0x10)>>1. An even s reaches entry bits 31:0 and an odd s reaches bits 63:32. A written half reads back as written, except for bit 14.
- R6: A window write whose entry index is at or beyond NPINS is dropped, and so is a write with select 0x03 to 0x0F. Window reads of those selects return 0.
- R7: Bit 14 of an entry is the in-service flag and cannot be written through the window. A low-half write clears it. A high-half write keeps it. A pulse on `rirr_set[i]` sets it, and a set wins over a low-half write in the same cycle.
- R8: A write is accepted only when `bus_size` is 4 or 8. For both sizes `bus_wdata` is the value written.
- R9: `mask_chg_pulse[i]` is high for exactly the one cycle after a low-half write that changed bit 16 of entry i, and low otherwise.
- R10: `entry_wr_pulse[i]` is high for exactly the one cycle after any accepted write to either half of entry i. At most one of its bits is ever high.
- R11: `route_entries[64*i +: 64]` is entry i. It changes only in the cycle after a write to the entry or a set of its in-service flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_off | input | 8 | Byte offset inside the 256-byte window |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rirr_set | input | NPINS | Per-pin in-service set from the pin logic |
| route_entries | output | 64*NPINS | All routing entries, entry i at bits 64*i +: 64 |
| mask_chg_pulse | output | NPINS | One-cycle pulse per pin when a write flips its mask |
| entry_wr_pulse | output | NPINS | One-cycle pulse per pin after any write to its entry |

## Verification
Every register result is due one edge after its stimulus. The table outputs and both pulse vectors change at the edge that samples the write, and read data is loaded at the edge that samples `bus_rd`. The bench drives each access at a falling edge and removes it at the next falling edge, and it samples all outputs at that same point. Each result is therefore observed in the single cycle in which it is valid. A pulse checked there must also be gone one cycle later, and the bench checks that too. The bench sweeps all 256 select values through the window against an arithmetic model of the table. It also writes and reads back both halves of every entry.

// File: rtl/irt_pkg.sv
package irt_pkg;
  localparam logic [7:0] OFS_SELECT = 8'h00;
  localparam logic [7:0] OFS_WINDOW = 8'h10;
  localparam logic [7:0] SEL_IDENT  = 8'h00;
  localparam logic [7:0] SEL_VERS   = 8'h01;
  localparam logic [7:0] SEL_IDMIR  = 8'h02;
  localparam logic [7:0] SEL_TABLE  = 8'h10;
  localparam int RIRR_BIT = 14;
  localparam int MASK_BIT = 16;
  localparam int ID_LSB   = 24;
  localparam int ID_W     = 4;
  localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;
endpackage

// File: rtl/irt_decode.sv
module irt_decode
  import irt_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int SEL_W = 8
) (
  input  logic             bus_wr,
  input  logic [7:0]       bus_off,
  input  logic [3:0]       bus_size,
  input  logic [SEL_W-1:0] sel_q,
  output logic             sel_we,
  output logic             id_we,
  output logic [NPINS-1:0] lo_we,
  output logic [NPINS-1:0] hi_we
);
  logic             wr_ok, win_we, in_rng;
  logic [SEL_W-1:0] rel, idx;

  always_comb begin
    wr_ok  = bus_wr && ((bus_size == 4'd4) || (bus_size == 4'd8));
    sel_we = wr_ok && (bus_off == OFS_SELECT);
    win_we = wr_ok && (bus_off == OFS_WINDOW);
    id_we  = win_we && (sel_q == SEL_W'(SEL_IDENT));
    rel    = sel_q - SEL_W'(SEL_TABLE);
    idx    = rel >> 1;
    in_rng = (sel_q >= SEL_W'(SEL_TABLE)) && (idx < SEL_W'(NPINS));
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_we
    assign lo_we[g] = win_we && in_rng && (idx == SEL_W'(g)) && !sel_q[0];
    assign hi_we[g] = win_we && in_rng && (idx == SEL_W'(g)) &&  sel_q[0];
  end
endmodule

// File: rtl/irt_entry.sv
module irt_entry
  import irt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lo_we,
  input  logic        hi_we,
  input  logic [31:0] wdata,
  input  logic        rirr_set,
  output logic [63:0] ent_q,
  output logic        mask_pulse,
  output logic        wr_pulse
);
  logic [63:0] ent_d;
  logic        ent_en, mask_pulse_d, wr_pulse_d;

  always_comb begin
    ent_d = ent_q;
    if (lo_we) begin
      ent_d[31:0]     = wdata;
      ent_d[RIRR_BIT] = 1'b0;
    end
    if (hi_we) ent_d[63:32] = wdata;
    if (rirr_set) ent_d[RIRR_BIT] = 1'b1;
    ent_en       = lo_we || hi_we || rirr_set;
    mask_pulse_d = lo_we && (wdata[MASK_BIT] != ent_q[MASK_BIT]);
    wr_pulse_d   = lo_we || hi_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q      <= ENTRY_RST;
      mask_pulse <= 1'b0;
      wr_pulse   <= 1'b0;
    end else begin
      if (ent_en) ent_q <= ent_d;
      mask_pulse <= mask_pulse_d;
      wr_pulse   <= wr_pulse_d;
    end
  end

  p_lowwr_clears_rirr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we && !rirr_set) |=> !ent_q[RIRR_BIT]);
  p_set_wins_rirr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rirr_set |=> ent_q[RIRR_BIT]);
  p_mask_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mask_pulse |-> (ent_q[MASK_BIT] != $past(ent_q[MASK_BIT])));
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_we || hi_we || rirr_set) |=> $stable(ent_q));
endmodule

// File: rtl/irt_readback.sv
module irt_readback
  import irt_pkg::*;
#(
  parameter int          NPINS   = 24,
  parameter int          SEL_W   = 8,
  parameter logic [7:0]  VERSION = 8'h11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd,
  input  logic [7:0]           off,
  input  logic [SEL_W-1:0]     sel_q,
  input  logic [ID_W-1:0]      id_q,
  input  logic [64*NPINS-1:0]  entries,
  output logic [31:0]          rdata
);
  localparam logic [7:0] TOP_PIN = 8'(NPINS - 1);

  logic [SEL_W-1:0] rel, idx;
  logic [63:0]      ent_sel;
  logic             in_rng;
  logic [31:0]      win_val, rdata_d;

  always_comb begin
    rel     = sel_q - SEL_W'(SEL_TABLE);
    idx     = rel >> 1;
    in_rng  = (sel_q >= SEL_W'(SEL_TABLE)) && (idx < SEL_W'(NPINS));
    ent_sel = '0;
    for (int i = 0; i < NPINS; i++)
      if (idx == SEL_W'(i)) ent_sel = entries[64*i +: 64];
    if ((sel_q == SEL_W'(SEL_IDENT)) || (sel_q == SEL_W'(SEL_IDMIR)))
      win_val = {id_q, {ID_LSB{1'b0}}};
    else if (sel_q == SEL_W'(SEL_VERS))
      win_val = {8'h00, TOP_PIN, 8'h00, VERSION};
    else if (in_rng)
      win_val = sel_q[0] ? ent_sel[63:32] : ent_sel[31:0];
    else
      win_val = '0;
    case (off)
      OFS_SELECT: rdata_d = 32'(sel_q);
      OFS_WINDOW: rdata_d = win_val;
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rdata_d;
  end

  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irt_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter int         SEL_W   = 8,
  parameter logic [7:0] VERSION = 8'h11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [7:0]          bus_off,
  input  logic [3:0]          bus_size,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NPINS-1:0]    rirr_set,
  output logic [64*NPINS-1:0] route_entries,
  output logic [NPINS-1:0]    mask_chg_pulse,
  output logic [NPINS-1:0]    entry_wr_pulse
);
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [ID_W-1:0]  id_q, id_d;
  logic             sel_we, id_we;
  logic [NPINS-1:0] lo_we, hi_we;

  irt_decode #(.NPINS(NPINS), .SEL_W(SEL_W)) u_dec (
    .bus_wr(bus_wr), .bus_off(bus_off), .bus_size(bus_size), .sel_q(sel_q),
    .sel_we(sel_we), .id_we(id_we), .lo_we(lo_we), .hi_we(hi_we));

  always_comb begin
    sel_d = bus_wdata[SEL_W-1:0];
    id_d  = bus_wdata[ID_LSB +: ID_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (sel_we) sel_q <= sel_d;
      if (id_we)  id_q  <= id_d;
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_ent
    irt_entry u_ent (
      .clk(clk), .rst_n(rst_n), .lo_we(lo_we[g]), .hi_we(hi_we[g]),
      .wdata(bus_wdata), .rirr_set(rirr_set[g]),
      .ent_q(route_entries[64*g +: 64]),
      .mask_pulse(mask_chg_pulse[g]), .wr_pulse(entry_wr_pulse[g]));
  end

  irt_readback #(.NPINS(NPINS), .SEL_W(SEL_W), .VERSION(VERSION)) u_rb (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .off(bus_off), .sel_q(sel_q),
    .id_q(id_q), .entries(route_entries), .rdata(bus_rdata));

  p_bad_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_size != 4'd4 && bus_size != 4'd8 && rirr_set == '0)
      |=> $stable(route_entries));
  p_idmirror_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_off == OFS_WINDOW && sel_q == SEL_W'(SEL_IDMIR)) |=> $stable(id_q));
  p_one_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(entry_wr_pulse));
  p_other_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off != OFS_SELECT) |=> $stable(sel_q));
endmodule

// File: tb/sim_irq_route_regs.sv
module sim_irq_route_regs;
  localparam int CLK_PERIOD = 10;
  localparam int N = 24;
  localparam logic [63:0] RST_ENT = 64'h0000_0000_0001_0000;

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_off = 0;
  logic [3:0] bus_size = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [N-1:0] rirr_set = 0, mask_chg_pulse, entry_wr_pulse;
  logic [64*N-1:0] route_entries;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [63:0] m_ent [N];
  logic [7:0] m_sel;
  logic [3:0] m_id;
  logic [N-1:0] last_mp, last_wp;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_route_regs u0 (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] off, logic [3:0] sz, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_off = off; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    last_mp = mask_chg_pulse; last_wp = entry_wr_pulse;
  endtask

  task automatic rd(logic [7:0] off, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_off = off;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] model_win(logic [7:0] s);
    logic [7:0] ix;
    if (s == 8'h00 || s == 8'h02) return {m_id, 24'h0};
    if (s == 8'h01) return 32'h0017_0011;
    if (s < 8'h10) return 32'h0;
    ix = (s - 8'h10) >> 1;
    if (ix >= N) return 32'h0;
    return s[0] ? m_ent[ix][63:32] : m_ent[ix][31:0];
  endfunction

  task automatic chk_table(string tag);
    for (int i = 0; i < N; i++) chk(tag, route_entries[64*i +: 64], m_ent[i]);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lo, hi;
    for (int i = 0; i < N; i++) m_ent[i] = RST_ENT;
    m_sel = 0; m_id = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk_table("R1 entry");
    chk("R1 pulses", {mask_chg_pulse, entry_wr_pulse}, '0);
    rd(8'h00, rv); chk("R1 select", rv, 0);
    rd(8'h10, rv); chk("R1 ident", rv, 0);
    // R3 identifier
    wr(8'h10, 4, 32'hFA5A_5A5A); m_id = 4'hA;
    rd(8'h10, rv); chk("R3 ident", rv, 32'h0A00_0000);
    wr(8'h00, 4, 32'h02); m_sel = 8'h02;
    rd(8'h10, rv); chk("R3 mirror", rv, 32'h0A00_0000);
    wr(8'h10, 4, 32'h0500_0000);
    rd(8'h10, rv); chk("R3 mirror ro", rv, 32'h0A00_0000);
    // R4 version
    wr(8'h00, 4, 32'h01);
    wr(8'h10, 4, 32'hFFFF_FFFF);
    rd(8'h10, rv); chk("R4 version", rv, 32'h0017_0011);
    chk_table("R4 no effect");
    // R5 R9 R10 R11 sweep over entries
    for (int i = 0; i < N; i++) begin
      lo = {8'(i*37), 7'h0, 1'(i % 2), 16'h4000 | 16'(i*257)};
      hi = 32'hC300_0000 | 32'(i*32'h0001_0203);
      wr(8'h00, 4, 32'h10 + 32'(2*i));
      wr(8'h10, 4, lo);
      m_ent[i][31:0] = lo; m_ent[i][14] = 1'b0;
      chk("R9 mask pulse", last_mp, (i % 2 == 0) ? (N'(1) << i) : '0);
      chk("R10 wr pulse lo", last_wp, N'(1) << i);
      chk("R11 after lo", route_entries[64*i +: 64], m_ent[i]);
      wr(8'h00, 8, 32'h11 + 32'(2*i));
      chk("R10 pulse ends", entry_wr_pulse, '0);
      wr(8'h10, 8, hi);
      m_ent[i][63:32] = hi;
      chk("R10 wr pulse hi", last_wp, N'(1) << i);
      chk("R9 no pulse hi", last_mp, '0);
    end
    chk_table("R11 table");
    // R5 R6 R3 R4 full select sweep
    for (int s = 0; s < 256; s++) begin
      wr(8'h00, 4, 32'(s));
      rd(8'h10, rv); chk("R5 R6 window sweep", rv, model_win(8'(s)));
    end
    // R6 dropped writes
    wr(8'h00, 4, 32'h40); wr(8'h10, 4, 32'h0);
    wr(8'h00, 4, 32'h7F); wr(8'h10, 4, 32'h0);
    wr(8'h00, 4, 32'h05); wr(8'h10, 4, 32'h0);
    chk_table("R6 dropped");
    chk("R6 no pulse", last_wp, '0);
    // R8 size filter
    for (int z = 0; z < 16; z++) begin
      if (z == 4 || z == 8) continue;
      wr(8'h00, 4'(z), 32'h12);
      rd(8'h00, rv); chk("R8 select bad size", rv, 32'h05);
      wr(8'h00, 4, 32'h12);
      wr(8'h10, 4'(z), 32'h0);
      chk_table("R8 entry bad size");
      wr(8'h00, 4, 32'h05);
    end
    // R2 other offsets
    for (int o = 0; o < 256; o++) begin
      if (o == 8'h00 || o == 8'h10) continue;
      wr(8'(o), 4, 32'hFF);
      rd(8'(o), rv); chk("R2 other offset read", rv, 0);
    end
    rd(8'h00, rv); chk("R2 select kept", rv, 32'h05);
    chk_table("R2 entries kept");
    // R7 in-service flag, entry 3
    @(negedge clk); rirr_set = N'(1) << 3;
    @(negedge clk); rirr_set = 0; m_ent[3][14] = 1'b1;
    chk("R7 set", route_entries[64*3 +: 64], m_ent[3]);
    wr(8'h00, 4, 32'h17); wr(8'h10, 4, 32'h1234_5678);
    m_ent[3][63:32] = 32'h1234_5678;
    chk("R7 hi keeps", route_entries[64*3 +: 64], m_ent[3]);
    wr(8'h00, 4, 32'h16); wr(8'h10, 4, m_ent[3][31:0]);
    m_ent[3][14] = 1'b0;
    chk("R7 lo clears", route_entries[64*3 +: 64], m_ent[3]);
    chk("R9 same mask no pulse", last_mp, '0);
    chk("R10 same mask wr pulse", last_wp, N'(1) << 3);
    @(negedge clk);
    bus_wr = 1; bus_off = 8'h10; bus_size = 4; bus_wdata = 32'h0001_0033;
    rirr_set = N'(1) << 3;
    @(negedge clk);
    bus_wr = 0; rirr_set = 0;
    m_ent[3][31:0] = 32'h0001_4033;
    chk("R7 set wins", route_entries[64*3 +: 64], m_ent[3]);
    rd(8'h10, rv); chk("R7 readback", rv, 32'h0001_4033);
    chk_table("R11 final");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule